// File: doc/BRIEF.md
# Programmable Video Sync and Data-Enable Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a raster video output, together with the current pixel column and line number. Software programs each axis with four numbers: the line or frame total, the blanking length, a sync delay and a sync duration. The sync delay is measured backwards from the end of the line (or frame) to the sync start. Active pixels come first on each line, and blanking follows. Front and back porch are never programmed directly. They follow from where the sync pulse sits inside the blanking interval.

Configuration arrives through a byte-wide write port. Every write lands in a shadow copy. The counters and decoders use a separate active copy, which is refreshed from the shadow at a frame boundary, or on every cycle while the generator is stopped. A new timing set therefore never tears a frame in progress. An interlace option alternates two fields. In the second field the vertical sync edges are moved by half a line.

Top module: `sync_timing_gen`

## Requirements
- R1: Reset clears all configuration to zero. During and right after reset, de_o=0, x_o=0, y_o=0 and field_o=0, and hsync_o=vsync_o=1, because zero polarity means active-low.
- R2: Register map on wr_addr, written with wr_en=1 and wr_data:
  - 0 is control: bit0 run enable, bit1 hsync polarity, bit2 vsync polarity, bit3 interlace.
  - 1/2 are line total low/high bytes; 3/4 line blank low/high; 5/6 hsync delay low/high; 7/8 hsync width low/high.
  - 9/10 are frame total low/high (in lines).
  - 11, 12 and 13 are single bytes: vertical blank, vsync delay and vsync width.
- R3: While running, x_o counts 0 up to line total minus 1 and then returns to 0.
- R4: y_o advances by one each time x_o wraps, and returns to 0 after frame total minus 1. It does not change within a line.
- R5: de_o is 1 exactly when x_o < total−blank on the horizontal axis and y_o < total−blank on the vertical axis.
- R6: The hsync pulse is active for x_o in [line total − hsync delay, that value + hsync width).
- R7: The vsync pulse is active for lines in [frame total − vsync delay, that value + vsync width). In field 0, or without interlace, the line is y_o.
- R8: With a polarity bit set to 1 the sync output is high while its pulse is active. With the bit at 0 the output is low while the pulse is active, and high otherwise.
- R9: While running, a write changes the active timing only from the first cycle of the next frame. While stopped, a write takes effect one cycle after it.
- R10: With interlace on, field_o toggles at each frame boundary. In field 1, the line used for vsync is y_o−1 while x_o < line total/2, so both vsync edges fall half a line later. Without interlace, field_o stays 0.
- R11: While the active run bit is 0, x_o=y_o=0, de_o=0, field_o=0, and both syncs sit at their inactive level.
- R12: Writes to addresses 14 and 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write byte |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable for active pixels |
| x_o | output | 16 | Current pixel column |
| y_o | output | 16 | Current line |
| field_o | output | 1 | Current field when interlaced |

## Verification
A small directed raster with both polarities active-high separates blank, delay and width errors on each axis. A second directed timing with line values above 255 exercises the high byte of each horizontal register. A mid-frame rewrite of the line total distinguishes shadowed updates from immediate ones. Interlaced frames show whether the half-line vsync shift and the field toggle happen. Seeded random timings then cover many ratios of blank, delay and width, with a cycle-level model in the bench predicting every output on every cycle.

// File: rtl/vtg_pkg.sv
// Shared constants and the timing configuration record.
// Assumes byte-wide register writes; wide fields are split into byte lanes.
package vtg_pkg;
    parameter int HW = 16;   // width of horizontal fields and x counter
    parameter int VW = 16;   // width of vertical total and y counter
    parameter int VSW = 8;   // width of short vertical fields
    parameter int AW = 4;    // register address width
    parameter int DW = 8;    // register data width

    localparam int HHI = HW - DW;  // bits held in a horizontal high byte
    localparam int VHI = VW - DW;  // bits held in the vertical total high byte

    localparam logic [AW-1:0] A_CTRL   = 4'd0;
    localparam logic [AW-1:0] A_HTOT_L = 4'd1;
    localparam logic [AW-1:0] A_HTOT_H = 4'd2;
    localparam logic [AW-1:0] A_HBLK_L = 4'd3;
    localparam logic [AW-1:0] A_HBLK_H = 4'd4;
    localparam logic [AW-1:0] A_HDLY_L = 4'd5;
    localparam logic [AW-1:0] A_HDLY_H = 4'd6;
    localparam logic [AW-1:0] A_HDUR_L = 4'd7;
    localparam logic [AW-1:0] A_HDUR_H = 4'd8;
    localparam logic [AW-1:0] A_VTOT_L = 4'd9;
    localparam logic [AW-1:0] A_VTOT_H = 4'd10;
    localparam logic [AW-1:0] A_VBLK   = 4'd11;
    localparam logic [AW-1:0] A_VDLY   = 4'd12;
    localparam logic [AW-1:0] A_VDUR   = 4'd13;

    typedef struct packed {
        logic           en;
        logic           hpol;
        logic           vpol;
        logic           ilace;
        logic [HW-1:0]  htot;
        logic [HW-1:0]  hblk;
        logic [HW-1:0]  hdly;
        logic [HW-1:0]  hdur;
        logic [VW-1:0]  vtot;
        logic [VSW-1:0] vblk;
        logic [VSW-1:0] vdly;
        logic [VSW-1:0] vdur;
    } tcfg_t;
endpackage

// File: rtl/vtg_regs.sv
// Shadow and active timing registers.
// Writes land in the shadow copy; the active copy follows it whenever
// load is high (generator stopped, or last cycle of a frame).
module vtg_regs
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          load,
    output tcfg_t         shadow,
    output tcfg_t         active
);
    // Byte-lane writes into the shadow configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    shadow.en    <= wr_data[0];
                    shadow.hpol  <= wr_data[1];
                    shadow.vpol  <= wr_data[2];
                    shadow.ilace <= wr_data[3];
                end
                A_HTOT_L: shadow.htot[DW-1:0]  <= wr_data;
                A_HTOT_H: shadow.htot[HW-1:DW] <= wr_data[HHI-1:0];
                A_HBLK_L: shadow.hblk[DW-1:0]  <= wr_data;
                A_HBLK_H: shadow.hblk[HW-1:DW] <= wr_data[HHI-1:0];
                A_HDLY_L: shadow.hdly[DW-1:0]  <= wr_data;
                A_HDLY_H: shadow.hdly[HW-1:DW] <= wr_data[HHI-1:0];
                A_HDUR_L: shadow.hdur[DW-1:0]  <= wr_data;
                A_HDUR_H: shadow.hdur[HW-1:DW] <= wr_data[HHI-1:0];
                A_VTOT_L: shadow.vtot[DW-1:0]  <= wr_data;
                A_VTOT_H: shadow.vtot[VW-1:DW] <= wr_data[VHI-1:0];
                A_VBLK:   shadow.vblk <= wr_data[VSW-1:0];
                A_VDLY:   shadow.vdly <= wr_data[VSW-1:0];
                A_VDUR:   shadow.vdur <= wr_data[VSW-1:0];
                default: ;
            endcase
        end
    end

    // Transfer shadow to active at the permitted moments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (load) begin
            active <= shadow;
        end
    end
endmodule

// File: rtl/vtg_axis_counter.sv
// One raster axis counter: advances on step and wraps after limit-1.
// Held at zero while run is low. A limit of 0 or 1 wraps on every step.
module vtg_axis_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         last
);
    localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

    // Wrap point flag: the current count is the final position of the axis.
    always_comb begin
        last = run && (({1'b0, cnt} + ONE) >= {1'b0, limit});
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vtg_sync_decode.sv
// Combinational decode of DE and both sync pulses from the counters.
// Assumes delay <= total on each axis; other values yield no pulse.
module vtg_sync_decode
    import vtg_pkg::*;
(
    input  tcfg_t         cfg,
    input  logic          run,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic          field,
    output logic          de,
    output logic          hsync,
    output logic          vsync
);
    localparam int VPAD = VW - VSW + 1;

    logic [HW:0]   hx, h_act, hs_start, hs_stop, h_half;
    logic [VW:0]   vx, v_act, vs_start, vs_stop;
    logic [VW+1:0] vline;
    logic          odd_shift, hpulse, vpulse;

    // Active-area and horizontal sync window.
    always_comb begin
        hx       = {1'b0, hcnt};
        vx       = {1'b0, vcnt};
        h_act    = {1'b0, cfg.htot} - {1'b0, cfg.hblk};
        v_act    = {1'b0, cfg.vtot} - {{VPAD{1'b0}}, cfg.vblk};
        hs_start = {1'b0, cfg.htot} - {1'b0, cfg.hdly};
        hs_stop  = hs_start + {1'b0, cfg.hdur};
        de       = run && (hx < h_act) && (vx < v_act);
        hpulse   = run && (hx >= hs_start) && (hx < hs_stop);
    end

    // Vertical sync window, shifted half a line in the second field.
    always_comb begin
        h_half    = {1'b0, cfg.htot} >> 1;
        odd_shift = field && (hx < h_half);
        vline     = {1'b0, vx} - {{(VW + 1){1'b0}}, odd_shift};
        vs_start  = {1'b0, cfg.vtot} - {{VPAD{1'b0}}, cfg.vdly};
        vs_stop   = vs_start + {{VPAD{1'b0}}, cfg.vdur};
        vpulse    = run && !vline[VW+1] &&
                    (vline[VW:0] >= vs_start) && (vline[VW:0] < vs_stop);
    end

    // Apply the programmed polarity.
    always_comb begin
        hsync = cfg.hpol ? hpulse : ~hpulse;
        vsync = cfg.vpol ? vpulse : ~vpulse;
    end
endmodule

// File: rtl/sync_timing_gen.sv
// Top of the programmable sync/DE generator.
// Joins the register bank, the two axis counters, the field flag and the
// output decoder. All outputs are aligned to the same counter position.
module sync_timing_gen
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [7:0]    wr_data,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [15:0]   x_o,
    output logic [15:0]   y_o,
    output logic          field_o
);
    tcfg_t         shadow_cfg, act_cfg;
    logic          run, h_last, v_last, frame_end, load, field_q;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;

    // Control strobes derived from the active state.
    always_comb begin
        run       = act_cfg.en;
        frame_end = h_last && v_last;
        load      = !run || frame_end;
    end

    vtg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .shadow  (shadow_cfg),
        .active  (act_cfg)
    );

    vtg_axis_counter #(.W(HW)) u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (1'b1),
        .limit (act_cfg.htot),
        .cnt   (hcnt),
        .last  (h_last)
    );

    vtg_axis_counter #(.W(VW)) u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (h_last),
        .limit (act_cfg.vtot),
        .cnt   (vcnt),
        .last  (v_last)
    );

    // Field flag: toggles per frame when the incoming timing is interlaced.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            field_q <= 1'b0;
        end else if (frame_end) begin
            field_q <= (shadow_cfg.ilace && shadow_cfg.en) ? ~field_q : 1'b0;
        end
    end

    vtg_sync_decode u_dec (
        .cfg   (act_cfg),
        .run   (run),
        .hcnt  (hcnt),
        .vcnt  (vcnt),
        .field (field_q),
        .de    (de_o),
        .hsync (hsync_o),
        .vsync (vsync_o)
    );

    // Position and field outputs.
    always_comb begin
        x_o     = hcnt;
        y_o     = vcnt;
        field_o = field_q;
    end
endmodule

// File: rtl/vtg_checker.sv
// Temporal checks on the generator, attached by bind.
// Observes the top ports plus the active configuration and frame strobe.
module vtg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        frame_end,
    input logic        act_ilace,
    input logic [15:0] act_htot,
    input logic [15:0] x_o,
    input logic [15:0] y_o,
    input logic        de_o,
    input logic        field_o
);
    // R3: column never reaches the line total.
    p_x_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_htot != 16'd0) |-> (x_o < act_htot));

    // R4: line number holds except at a column wrap.
    p_y_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && x_o != 16'd0) |-> $stable(y_o));

    // R5: data enable only while running.
    p_de_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> run);

    // R11: stopped generator rests at the origin.
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (x_o == 16'd0 && y_o == 16'd0 && !de_o && !field_o));

    // R10: no second field without interlace.
    p_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !act_ilace |-> !field_o);

    // R9: active timing frozen inside a running frame.
    p_frozen_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(frame_end)) |-> $stable(act_htot));
endmodule

bind sync_timing_gen vtg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (act_cfg.en),
    .frame_end (frame_end),
    .act_ilace (act_cfg.ilace),
    .act_htot  (act_cfg.htot),
    .x_o       (x_o),
    .y_o       (y_o),
    .de_o      (de_o),
    .field_o   (field_o)
);

// File: tb/sync_timing_gen_tb.sv
`timescale 1ns/1ps
module sync_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        hsync_o, vsync_o, de_o, field_o;
    logic [15:0] x_o, y_o;

    always #2 clk = ~clk;

    sync_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .x_o(x_o), .y_o(y_o), .field_o(field_o)
    );

    typedef struct {
        int en, hp, vp, il, ht, hb, hd, hu, vt, vb, vd, vu;
    } mcfg_t;

    mcfg_t sh, ac;
    int    m_x, m_y, m_f;
    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // Record one comparison.
    task automatic chk(string r, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] x=%0d y=%0d: actual %0d expected %0d",
                     r, tag, m_x, m_y, act, exp);
        end
    endtask

    function automatic int exp_de();
        if (ac.en == 0) return 0;
        return (m_x < ac.ht - ac.hb && m_y < ac.vt - ac.vb) ? 1 : 0;
    endfunction

    function automatic int exp_hs();
        int s, p;
        s = ac.ht - ac.hd;
        p = (ac.en != 0 && m_x >= s && m_x < s + ac.hu) ? 1 : 0;
        return ac.hp != 0 ? p : 1 - p;
    endfunction

    function automatic int exp_vs();
        int s, p, vl;
        vl = m_y - ((m_f != 0 && m_x < ac.ht / 2) ? 1 : 0);
        s = ac.vt - ac.vd;
        p = (ac.en != 0 && vl >= 0 && vl >= s && vl < s + ac.vu) ? 1 : 0;
        return ac.vp != 0 ? p : 1 - p;
    endfunction

    // Shadow write model per the register map (R2, R12).
    function automatic void apply_wr(int a, int d);
        case (a)
            0: begin sh.en = d & 1; sh.hp = (d >> 1) & 1;
                     sh.vp = (d >> 2) & 1; sh.il = (d >> 3) & 1; end
            1: sh.ht = (sh.ht & 'hff00) | d;
            2: sh.ht = (sh.ht & 'hff) | (d << 8);
            3: sh.hb = (sh.hb & 'hff00) | d;
            4: sh.hb = (sh.hb & 'hff) | (d << 8);
            5: sh.hd = (sh.hd & 'hff00) | d;
            6: sh.hd = (sh.hd & 'hff) | (d << 8);
            7: sh.hu = (sh.hu & 'hff00) | d;
            8: sh.hu = (sh.hu & 'hff) | (d << 8);
            9: sh.vt = (sh.vt & 'hff00) | d;
            10: sh.vt = (sh.vt & 'hff) | (d << 8);
            11: sh.vb = d;
            12: sh.vd = d;
            13: sh.vu = d;
            default: ;
        endcase
    endfunction

    // One cycle: check current outputs, drive inputs, advance the model.
    task automatic tick(bit we, int a, int d);
        int run, hl, vl, fe, nx, ny, nf;
        @(negedge clk);
        chk("R3", int'(x_o), m_x);
        chk("R4", int'(y_o), m_y);
        chk("R5", int'(de_o), exp_de());
        chk("R6", int'(hsync_o), exp_hs());
        chk("R7", int'(vsync_o), exp_vs());
        chk("R10", int'(field_o), m_f);
        wr_en = we;
        wr_addr = 4'(a);
        wr_data = 8'(d);
        run = ac.en;
        hl = (run != 0 && m_x + 1 >= ac.ht) ? 1 : 0;
        vl = (run != 0 && m_y + 1 >= ac.vt) ? 1 : 0;
        fe = hl & vl;
        nx = (run == 0 || hl != 0) ? 0 : m_x + 1;
        ny = (run == 0) ? 0 : (hl != 0 ? (vl != 0 ? 0 : m_y + 1) : m_y);
        nf = (run == 0) ? 0 :
             (fe != 0 ? ((sh.il != 0 && sh.en != 0) ? 1 - m_f : 0) : m_f);
        if (run == 0 || fe != 0) ac = sh;
        if (we) apply_wr(a, d);
        m_x = nx; m_y = ny; m_f = nf;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic prog(int ht, int hb, int hd, int hu, int vt, int vb,
                        int vd, int vu, int ctrl);
        tick(1, 1, ht & 'hff);  tick(1, 2, ht >> 8);
        tick(1, 3, hb & 'hff);  tick(1, 4, hb >> 8);
        tick(1, 5, hd & 'hff);  tick(1, 6, hd >> 8);
        tick(1, 7, hu & 'hff);  tick(1, 8, hu >> 8);
        tick(1, 9, vt & 'hff);  tick(1, 10, vt >> 8);
        tick(1, 11, vb); tick(1, 12, vd); tick(1, 13, vu);
        tick(1, 0, ctrl);
    endtask

    function automatic int frame_len();
        return (ac.ht > sh.ht ? ac.ht : sh.ht) * (ac.vt > sh.vt ? ac.vt : sh.vt);
    endfunction

    initial begin
        int ht, hb, hd, hu, vt, vb, vd, vu;
        int seed;
        seed = $urandom(32'd20240611);
        sh = '{default: 0}; ac = '{default: 0};
        m_x = 0; m_y = 0; m_f = 0;
        repeat (3) @(negedge clk);
        // R1: state while held in reset
        chk("R1", int'(de_o), 0);   chk("R1", int'(hsync_o), 1);
        chk("R1", int'(vsync_o), 1); chk("R1", int'(x_o), 0);
        chk("R1", int'(y_o), 0);    chk("R1", int'(field_o), 0);
        rst_n = 1'b1;
        idle(2);

        // R2 with R8 active-high polarity
        tag = "R2";
        prog(20, 6, 5, 2, 10, 3, 2, 1, 'b0111);
        idle(2 * frame_len() + 5);
        // R2 high bytes
        prog(300, 280, 270, 258, 3, 1, 1, 1, 'b0111);
        idle(2 * frame_len() + 5);
        prog(20, 6, 5, 2, 10, 3, 2, 1, 'b0111);
        idle(2 * frame_len() + 5);

        // R8: active-low both syncs
        tag = "R8";
        tick(1, 0, 'b0001);
        idle(2 * frame_len() + 5);
        tick(1, 0, 'b0010);
        tick(1, 0, 'b0011);
        idle(2 * frame_len() + 5);

        // R9: mid-frame change of line total
        tag = "R9";
        idle(37);
        tick(1, 1, 24);
        idle(2 * frame_len() + 5);

        // R12: unmapped addresses
        tag = "R12";
        tick(1, 14, 'hff);
        tick(1, 15, 'h00);
        idle(2 * frame_len() + 5);

        // R10: interlaced fields
        tag = "R10";
        tick(1, 0, 'b1111);
        idle(4 * frame_len() + 5);
        tick(1, 0, 'b0111);
        idle(2 * frame_len() + 5);

        // R11: stop the generator
        tag = "R11";
        tick(1, 0, 'b0110);
        idle(frame_len() + 10);
        tick(1, 1, 12);
        idle(3);

        // Random timings
        tag = "R2";
        for (int k = 0; k < 8; k++) begin
            ht = 8 + $urandom % 33;
            hb = 1 + $urandom % (ht - 2);
            hd = 1 + $urandom % hb;
            hu = 1 + $urandom % hd;
            vt = 4 + $urandom % 9;
            vb = 1 + $urandom % (vt - 2);
            vd = 1 + $urandom % vb;
            vu = 1 + $urandom % vd;
            prog(ht, hb, hd, hu, vt, vb, vd, vu,
                 1 | (($urandom % 8) << 1));
            idle(3 * frame_len() + 5);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end
endmodule